// File: doc/BRIEF.md
# Indirect Register Window

This block is a host-facing register front end that reaches a large internal register space through a handful of directly mapped 16-bit registers. The host sees a control/status word, a fixed identification word, a transaction address word and four data words on a simple bus with an address, separate write and read strobes and 16-bit data. Each direct register sits on its own 16-byte slot.

Writing the transaction address word launches exactly one access to an internal register. That access leaves the block on a request/acknowledge port carrying the block type, instance, direction, parameter select and word index fields, together with all four staged data words. Registers wider than 16 bits are written by staging up to four words first and then writing the address. They are read one 16-bit word per transaction, the word being chosen by the index field, and each returned word lands in data word 0.

The control/status word also drives three configuration pins: two active-low reset lines and a mode select.

Top module: `ireg_window`

## Requirements
- R1: After reset the status word reads 0x0000, both reset outputs (glob_rst_n, codec_rst_n) and quad_mode are low, ip_req is low, and all four data words read 0x0000.
- R2: The word at offset 0x20 reads {audio_absent, BOARD_REV[2:0], 4'b0000, CHIP_MAJOR[3:0], CHIP_MINOR[3:0]}. Bus writes to it have no effect.
- R3: A bus write to offset 0x30 while idle raises ip_req and status bit 0 (busy) in the next cycle. The written word is decoded as block type = bits 15:12, instance = 11:8, read = bit 7 (1 read, 0 write), parameter = 3:2 and index = 1:0, and these appear on ip_blk, ip_inst, ip_read, ip_param and ip_index.
- R4: ip_req and busy stay high until a cycle in which ip_ack is sampled high. Both are low in the following cycle.
- R5: A bus write to offset 0x30 while busy is ignored. The address word read back at 0x30 keeps the value of the running transaction, and no second request follows the acknowledge.
- R6: During every transaction ip_wdata carries {data3, data2, data1, data0}, where data0..data3 are the words at offsets 0x40, 0x50, 0x60 and 0x70.
- R7: On the acknowledge of a read transaction, ip_rdata is stored in data word 0 (offset 0x40). Data words 1 to 3 are unchanged, and a write transaction leaves data word 0 unchanged.
- R8: Bus writes to the data words while busy are ignored.
- R9: Status bits 2 (quad_mode), 3 (glob_rst_n) and 4 (codec_rst_n) are writable and drive the pins of the same name. Bit 0 is read-only busy, and bits 1 and 15:5 read 0.
- R10: bus_rdata is registered and shows the addressed word in the cycle after bus_rd. Any offset other than the seven mapped ones reads 0x0000.
- R11: While ip_req is high, all request fields and ip_wdata stay stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | AW (8) | Host byte address |
| bus_wr | input | 1 | Host write strobe |
| bus_rd | input | 1 | Host read strobe |
| bus_wdata | input | DW (16) | Host write data |
| bus_rdata | output | DW (16) | Registered host read data |
| audio_absent | input | 1 | Reported in identification bit 15 |
| quad_mode | output | 1 | Mode select from status bit 2 |
| glob_rst_n | output | 1 | Active-low global reset from status bit 3 |
| codec_rst_n | output | 1 | Active-low codec reset from status bit 4 |
| ip_req | output | 1 | Internal transaction request |
| ip_blk | output | 4 | Functional block type |
| ip_inst | output | 4 | Instance within the type |
| ip_read | output | 1 | 1 read, 0 write |
| ip_param | output | 2 | Parameter select |
| ip_index | output | 2 | Read-back word index |
| ip_wdata | output | NDATA*DW (64) | Staged data words {d3,d2,d1,d0} |
| ip_ack | input | 1 | Internal acknowledge |
| ip_rdata | input | DW (16) | Internal read word |

## Verification
A stuck or early-clearing busy flag shows at once, because ip_req either never rises or drops before ip_ack, and a status read one cycle later shows the wrong bit 0. A corrupted address latch or a busy write that gets through appears on the request fields in the same cycle, and on the 0x30 read-back one cycle after the read strobe. A wrong capture path shows up only on the next read of data word 0, after the acknowledge, so every read transaction is followed by that read. A staging fault is visible on ip_wdata as soon as the request is raised.

// File: rtl/ireg_pkg.sv
package ireg_pkg;
  // slot numbers: byte offset = slot * 16
  localparam int SLOT_STAT  = 1;
  localparam int SLOT_REV   = 2;
  localparam int SLOT_IADDR = 3;
  localparam int SLOT_DATA0 = 4;

  // transaction address word layout (16 bits)
  typedef struct packed {
    logic [3:0] blk;
    logic [3:0] inst;
    logic       rd;
    logic [2:0] spare;
    logic [1:0] param;
    logic [1:0] idx;
  } iaddr_t;
endpackage

// File: rtl/ireg_decode.sv
module ireg_decode
  import ireg_pkg::*;
#(
  parameter int AW    = 8,
  parameter int NDATA = 4
) (
  input  logic [AW-1:0]    addr,
  output logic             sel_stat,
  output logic             sel_rev,
  output logic             sel_iaddr,
  output logic [NDATA-1:0] sel_data
);
  localparam int SW = AW - 4;

  logic [SW-1:0] slot;
  logic          aligned;

  assign slot    = addr[AW-1:4];
  assign aligned = (addr[3:0] == 4'd0);

  assign sel_stat  = aligned && (slot == SW'(SLOT_STAT));
  assign sel_rev   = aligned && (slot == SW'(SLOT_REV));
  assign sel_iaddr = aligned && (slot == SW'(SLOT_IADDR));

  for (genvar i = 0; i < NDATA; i++) begin : g_dsel
    assign sel_data[i] = aligned && (slot == SW'(SLOT_DATA0 + i));
  end
endmodule

// File: rtl/ireg_seq.sv
module ireg_seq
  import ireg_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [DW-1:0] wdata,
  input  logic          ack,
  output logic          busy,
  output iaddr_t        iaddr_q,
  output logic          cap_en
);
  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      iaddr_q <= '0;
    end else if (!busy && start) begin
      iaddr_q <= iaddr_t'(wdata[15:0]);
      busy    <= 1'b1;
    end else if (busy && ack) begin
      busy    <= 1'b0;
    end
  end

  // returned word is taken only for a read that is being acknowledged
  assign cap_en = busy && ack && iaddr_q.rd;
endmodule

// File: rtl/ireg_dstage.sv
module ireg_dstage #(
  parameter int DW    = 16,
  parameter int NDATA = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [NDATA-1:0]    sel,
  input  logic [DW-1:0]       wdata,
  input  logic                cap_en,
  input  logic [DW-1:0]       cap_data,
  output logic [NDATA*DW-1:0] regs
);
  for (genvar i = 0; i < NDATA; i++) begin : g_word
    if (i == 0) begin : g_cap
      always_ff @(posedge clk) begin
        if (rst)                regs[0 +: DW] <= '0;
        else if (cap_en)        regs[0 +: DW] <= cap_data;
        else if (wr_en && sel[0]) regs[0 +: DW] <= wdata;
      end
    end else begin : g_plain
      always_ff @(posedge clk) begin
        if (rst)                regs[i*DW +: DW] <= '0;
        else if (wr_en && sel[i]) regs[i*DW +: DW] <= wdata;
      end
    end
  end
endmodule

// File: rtl/ireg_window.sv
module ireg_window
  import ireg_pkg::*;
#(
  parameter int         AW         = 8,
  parameter int         DW         = 16,
  parameter int         NDATA      = 4,
  parameter logic [2:0] BOARD_REV  = 3'd3,
  parameter logic [3:0] CHIP_MAJOR = 4'd2,
  parameter logic [3:0] CHIP_MINOR = 4'd5
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [AW-1:0]       bus_addr,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [DW-1:0]       bus_wdata,
  output logic [DW-1:0]       bus_rdata,
  input  logic                audio_absent,
  output logic                quad_mode,
  output logic                glob_rst_n,
  output logic                codec_rst_n,
  output logic                ip_req,
  output logic [3:0]          ip_blk,
  output logic [3:0]          ip_inst,
  output logic                ip_read,
  output logic [1:0]          ip_param,
  output logic [1:0]          ip_index,
  output logic [NDATA*DW-1:0] ip_wdata,
  input  logic                ip_ack,
  input  logic [DW-1:0]       ip_rdata
);
  logic             sel_stat, sel_rev, sel_iaddr;
  logic [NDATA-1:0] sel_data;
  logic             busy, cap_en;
  iaddr_t           iaddr_q;
  logic [NDATA*DW-1:0] dreg_flat;
  logic [DW-1:0]    data0_q;
  logic [DW-1:0]    rd_mux;
  logic [DW-1:0]    rev_word;
  logic [DW-1:0]    stat_word;

  ireg_decode #(.AW(AW), .NDATA(NDATA)) u_dec (
    .addr      (bus_addr),
    .sel_stat  (sel_stat),
    .sel_rev   (sel_rev),
    .sel_iaddr (sel_iaddr),
    .sel_data  (sel_data)
  );

  ireg_seq #(.DW(DW)) u_seq (
    .clk     (clk),
    .rst     (rst),
    .start   (bus_wr && sel_iaddr),
    .wdata   (bus_wdata),
    .ack     (ip_ack),
    .busy    (busy),
    .iaddr_q (iaddr_q),
    .cap_en  (cap_en)
  );

  ireg_dstage #(.DW(DW), .NDATA(NDATA)) u_dst (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (bus_wr && !busy),
    .sel      (sel_data),
    .wdata    (bus_wdata),
    .cap_en   (cap_en),
    .cap_data (ip_rdata),
    .regs     (dreg_flat)
  );

  assign data0_q = dreg_flat[DW-1:0];

  // configuration bits of the status word
  always_ff @(posedge clk) begin
    if (rst) begin
      quad_mode   <= 1'b0;
      glob_rst_n  <= 1'b0;
      codec_rst_n <= 1'b0;
    end else if (bus_wr && sel_stat) begin
      quad_mode   <= bus_wdata[2];
      glob_rst_n  <= bus_wdata[3];
      codec_rst_n <= bus_wdata[4];
    end
  end

  assign stat_word = DW'({codec_rst_n, glob_rst_n, quad_mode, 1'b0, busy});
  assign rev_word  = DW'({audio_absent, BOARD_REV, 4'b0000, CHIP_MAJOR, CHIP_MINOR});

  always_comb begin
    rd_mux = '0;
    if (sel_stat)  rd_mux = stat_word;
    if (sel_rev)   rd_mux = rev_word;
    if (sel_iaddr) rd_mux = DW'(iaddr_q);
    for (int i = 0; i < NDATA; i++) begin
      if (sel_data[i]) rd_mux = dreg_flat[i*DW +: DW];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  assign ip_req   = busy;
  assign ip_blk   = iaddr_q.blk;
  assign ip_inst  = iaddr_q.inst;
  assign ip_read  = iaddr_q.rd;
  assign ip_param = iaddr_q.param;
  assign ip_index = iaddr_q.idx;
  assign ip_wdata = dreg_flat;
endmodule

// File: rtl/ireg_window_chk.sv
module ireg_window_chk
  import ireg_pkg::*;
#(
  parameter int AW    = 8,
  parameter int DW    = 16,
  parameter int NDATA = 4
) (
  input logic                clk,
  input logic                rst,
  input logic                bus_wr,
  input logic [AW-1:0]       bus_addr,
  input logic                ip_req,
  input logic                ip_ack,
  input logic                ip_read,
  input logic [3:0]          ip_blk,
  input logic [3:0]          ip_inst,
  input logic [1:0]          ip_param,
  input logic [1:0]          ip_index,
  input logic [NDATA*DW-1:0] ip_wdata,
  input logic [DW-1:0]       ip_rdata,
  input logic [DW-1:0]       data0
);
  localparam logic [AW-1:0] IADDR_OFS = AW'(SLOT_IADDR * 16);

  assert_start_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(ip_req) |-> ($past(bus_wr) && $past(bus_addr) == IADDR_OFS));

  assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (ip_req && !ip_ack) |=> ip_req);

  assert_drop_R4: assert property (@(posedge clk) disable iff (rst)
    (ip_req && ip_ack) |=> !ip_req);

  assert_capture_R7: assert property (@(posedge clk) disable iff (rst)
    (ip_req && ip_ack && ip_read) |=> (data0 == $past(ip_rdata)));

  assert_stable_R11: assert property (@(posedge clk) disable iff (rst)
    (ip_req && $past(ip_req) && !$past(ip_ack)) |->
      ($stable(ip_blk) && $stable(ip_inst) && $stable(ip_read) &&
       $stable(ip_param) && $stable(ip_index) && $stable(ip_wdata)));
endmodule

bind ireg_window ireg_window_chk #(.AW(AW), .DW(DW), .NDATA(NDATA)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .bus_wr   (bus_wr),
  .bus_addr (bus_addr),
  .ip_req   (ip_req),
  .ip_ack   (ip_ack),
  .ip_read  (ip_read),
  .ip_blk   (ip_blk),
  .ip_inst  (ip_inst),
  .ip_param (ip_param),
  .ip_index (ip_index),
  .ip_wdata (ip_wdata),
  .ip_rdata (ip_rdata),
  .data0    (data0_q)
);

// File: tb/sim_ireg_window.sv
module sim_ireg_window;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        audio_absent = 1'b0;
  logic        quad_mode, glob_rst_n, codec_rst_n;
  logic        ip_req, ip_read;
  logic [3:0]  ip_blk, ip_inst;
  logic [1:0]  ip_param, ip_index;
  logic [63:0] ip_wdata;
  logic        ip_ack = 1'b0;
  logic [15:0] ip_rdata = '0;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  ireg_window u0 (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .audio_absent(audio_absent),
    .quad_mode(quad_mode), .glob_rst_n(glob_rst_n), .codec_rst_n(codec_rst_n),
    .ip_req(ip_req), .ip_blk(ip_blk), .ip_inst(ip_inst), .ip_read(ip_read),
    .ip_param(ip_param), .ip_index(ip_index), .ip_wdata(ip_wdata),
    .ip_ack(ip_ack), .ip_rdata(ip_rdata)
  );

  // read transactions: {address word, returned word}
  localparam logic [31:0] RD_VEC [6] = '{
    32'h1281_A5A5, 32'h3183_0F0F, 32'h228E_1234,
    32'h9180_FFFF, 32'h2384_0001, 32'h1580_8000
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [15:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic ack_once(input logic [15:0] resp);
    ip_ack = 1'b1; ip_rdata = resp;
    @(negedge clk); ip_ack = 1'b0; ip_rdata = '0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 ip_req", ip_req, 0);
    chk("R1 glob_rst_n", glob_rst_n, 0);
    chk("R1 codec_rst_n", codec_rst_n, 0);
    chk("R1 quad_mode", quad_mode, 0);
    bus_read(8'h10, v); chk("R1 status", v, 16'h0000);
    for (int i = 0; i < 4; i++) begin
      bus_read(8'h40 + 8'(i * 16), v); chk("R1 data word", v, 16'h0000);
    end

    // R2 identification word
    bus_read(8'h20, v); chk("R2 rev", v, 16'h3025);
    bus_write(8'h20, 16'hFFFF);
    bus_read(8'h20, v); chk("R2 rev after write", v, 16'h3025);
    audio_absent = 1'b1;
    bus_read(8'h20, v); chk("R2 rev absent", v, 16'hB025);
    audio_absent = 1'b0;

    // R9 status control bits
    bus_write(8'h10, 16'hFFFF);
    chk("R9 quad_mode", quad_mode, 1);
    chk("R9 glob_rst_n", glob_rst_n, 1);
    chk("R9 codec_rst_n", codec_rst_n, 1);
    bus_read(8'h10, v); chk("R9 status readback", v, 16'h001C);
    bus_write(8'h10, 16'h0008);
    chk("R9 codec_rst_n low", codec_rst_n, 0);
    chk("R9 quad low", quad_mode, 0);

    // R10 unmapped offsets
    bus_read(8'h08, v); chk("R10 unaligned", v, 16'h0000);
    bus_read(8'h80, v); chk("R10 above map", v, 16'h0000);
    bus_read(8'h00, v); chk("R10 slot zero", v, 16'h0000);

    // R6 / R3 wide write transaction
    bus_write(8'h40, 16'h1111);
    bus_write(8'h50, 16'h2222);
    bus_write(8'h60, 16'h3333);
    bus_write(8'h70, 16'h4444);
    bus_write(8'h30, 16'h1404);
    chk("R3 req high", ip_req, 1);
    chk("R3 blk", ip_blk, 4'h1);
    chk("R3 inst", ip_inst, 4'h4);
    chk("R3 read bit", ip_read, 0);
    chk("R3 param", ip_param, 2'd1);
    chk("R3 index", ip_index, 2'd0);
    chk("R6 wdata", ip_wdata, 64'h4444_3333_2222_1111);
    bus_read(8'h10, v); chk("R3 busy bit", v, 16'h0009);
    // R5 address write while busy
    bus_write(8'h30, 16'h2383);
    bus_read(8'h30, v); chk("R5 addr kept", v, 16'h1404);
    chk("R5 blk kept", ip_blk, 4'h1);
    // R8 data write while busy
    bus_write(8'h40, 16'hBEEF);
    bus_read(8'h40, v); chk("R8 data0 kept", v, 16'h1111);
    chk("R4 req held", ip_req, 1);
    ack_once(16'hDEAD);
    chk("R4 req dropped", ip_req, 0);
    bus_read(8'h10, v); chk("R4 busy cleared", v, 16'h0008);
    repeat (3) @(negedge clk);
    chk("R5 no second request", ip_req, 0);
    bus_read(8'h40, v); chk("R7 write txn keeps data0", v, 16'h1111);

    // R7 read transactions from the table
    for (int k = 0; k < 6; k++) begin
      logic [15:0] aw, resp;
      aw = RD_VEC[k][31:16];
      resp = RD_VEC[k][15:0];
      bus_write(8'h30, aw);
      chk("R3 table req", ip_req, 1);
      chk("R3 table blk", ip_blk, aw[15:12]);
      chk("R3 table inst", ip_inst, aw[11:8]);
      chk("R3 table read", ip_read, aw[7]);
      chk("R3 table param", ip_param, aw[3:2]);
      chk("R3 table index", ip_index, aw[1:0]);
      ack_once(resp);
      chk("R4 table drop", ip_req, 0);
      bus_read(8'h40, v); chk("R7 data0 capture", v, resp);
    end
    bus_read(8'h50, v); chk("R7 data1 kept", v, 16'h2222);
    bus_read(8'h70, v); chk("R7 data3 kept", v, 16'h4444);
    chk("R6 wdata after reads", ip_wdata, 64'h4444_3333_2222_8000);

    // R8 data writes accepted again when idle
    bus_write(8'h60, 16'h5A5A);
    bus_read(8'h60, v); chk("R8 idle write", v, 16'h5A5A);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule